// File: doc/BRIEF.md
# Banked Fault-Status Register Access Controller

This block holds a 32-bit auxiliary fault status register and serves the coprocessor-move accesses that read or write it. The register exists as a secure copy, a non-secure copy and a single unbanked copy. Which of the three an access reaches depends on the privilege level and the security state of the requester. Each request carries the five encoding fields of the move instruction, a read/write flag and write data.

When the encoding names this register, the block decides the outcome in the same cycle. The outcome is one of four: the access is undefined, it traps to the hypervisor in 64-bit-state style, it traps to the hypervisor in 32-bit-state style (both traps carry a syndrome code), or it completes. A completed read returns the selected copy combinationally. A completed write lands in the selected copy at the next clock edge.

At the lowest privilege level every access is refused. At the supervisor level two hypervisor trap sources are checked in a fixed order before the bank is chosen. At the hypervisor and monitor levels no traps apply. The configuration flags that describe which levels exist, and in which execution width they run, are static inputs.

Top module: `bsr_access_ctrl`

## Requirements
- R1: `hit` is high only when coproc=4'b1111, opc1=3'b000, CRn=4'b0101, CRm=4'b0001 and opc2=3'b000. With any other encoding, and whenever `req_valid` is low, all four outcome outputs stay low and no copy changes.
- R2: When `cur_el`=0 (unprivileged), a matching request gives `res_undef`=1 and no copy changes.
- R3: When `cur_el`=1, `el2_enabled`=1 and the register-group trap bit is set, the access traps with `trap_code`=6'h03. Only the copy of that bit that matches the hypervisor width counts: `hyp_grp_trap_w32` when `el2_is32`=1, otherwise `hyp_grp_trap_w64`. The style is `res_trap_w32` when `el2_is32`=1, otherwise `res_trap_w64`.
- R4: When `cur_el`=1, `el2_enabled`=1 and the group trap is not taken, a read traps on the read-side memory-control trap bit and a write traps on the write-side bit. The width selection, code 6'h03 and style are the same as in R3. A group trap and a memory-control trap never occur together; the group trap is checked first.
- R5: When `el2_enabled`=0, no trap bit has any effect at `cur_el`=1.
- R6: At `cur_el`=1 with no trap, the access completes to the secure copy when `nonsecure`=0 and to the non-secure copy when `nonsecure`=1, provided that `el3_present`=1 and `el3_is32`=1. Otherwise it completes to the unbanked copy.
- R7: At `cur_el`=2, the access always completes, whatever the trap bits. It reaches the non-secure copy when `el3_present`=1 and `el3_is32`=1, and the unbanked copy otherwise.
- R8: At `cur_el`=3, the access always completes, to the secure copy when `nonsecure`=0 and to the non-secure copy when `nonsecure`=1.
- R9: For a valid matching request, exactly one of `res_undef`, `res_trap_w64`, `res_trap_w32` and `res_ok` is high in the request's own cycle. `trap_code` is 0 unless a trap output is high.
- R10: A write updates the selected copy at the next rising edge, and only when `res_ok` is high and `rst_n` is high. A read with `res_ok` returns the selected copy on `rdata`. Otherwise `rdata` is 0. The contents after reset are undefined.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; blocks writes while low |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write (move to register), 0 = read |
| enc_coproc | input | 4 | Coprocessor number field |
| enc_opc1 | input | 3 | First opcode field |
| enc_crn | input | 4 | Primary register field |
| enc_crm | input | 4 | Secondary register field |
| enc_opc2 | input | 3 | Second opcode field |
| wdata | input | 32 | Write data |
| cur_el | input | 2 | Current privilege level, 0 to 3 |
| nonsecure | input | 1 | Security state bit, 1 = non-secure |
| el2_enabled | input | 1 | Hypervisor level enabled |
| el2_is32 | input | 1 | Hypervisor runs in 32-bit state |
| el3_present | input | 1 | Monitor level implemented |
| el3_is32 | input | 1 | Monitor runs in 32-bit state |
| hyp_grp_trap_w64 | input | 1 | Register-group trap bit, 64-bit hypervisor copy |
| hyp_grp_trap_w32 | input | 1 | Register-group trap bit, 32-bit hypervisor copy |
| hyp_vmrd_trap_w64 | input | 1 | Memory-control read trap, 64-bit copy |
| hyp_vmrd_trap_w32 | input | 1 | Memory-control read trap, 32-bit copy |
| hyp_vmwr_trap_w64 | input | 1 | Memory-control write trap, 64-bit copy |
| hyp_vmwr_trap_w32 | input | 1 | Memory-control write trap, 32-bit copy |
| hit | output | 1 | Encoding names this register |
| res_undef | output | 1 | Undefined-instruction outcome |
| res_trap_w64 | output | 1 | Trap to hypervisor, 64-bit style |
| res_trap_w32 | output | 1 | Trap to hypervisor, 32-bit style |
| res_ok | output | 1 | Access completes |
| trap_code | output | 6 | Syndrome code of a trap, else 0 |
| rdata | output | 32 | Read data of a completed read |

## Verification
The bench sweeps every combination of privilege level, the four configuration flags, the security bit, the direction and all 64 patterns of the six trap bits. That separates group-over-memory-control priority, read-versus-write trap bit choice, and width-matched versus mismatched trap copies. Each write carries distinct data, and later completed reads are compared against a bench model of the three copies. This exposes writes that landed in the wrong copy, and writes that were refused but still changed storage. Single-bit corruptions of each encoding field, and idle cycles with a matching encoding, show that mismatches never act.

// File: rtl/bsr_pkg.sv
// Shared types and constants of the banked fault-status register controller.
// Assumes a 2-bit privilege level and three storage copies.
package bsr_pkg;

    typedef enum logic [1:0] {
        BANK_SEC = 2'd0,
        BANK_NS  = 2'd1,
        BANK_ONE = 2'd2
    } bank_e;

    localparam int NUM_BANKS = 3;

    typedef enum logic [1:0] {
        LVL_USER  = 2'd0,
        LVL_SUPV  = 2'd1,
        LVL_HYP   = 2'd2,
        LVL_MON   = 2'd3
    } level_e;

    typedef struct packed {
        logic undef;
        logic trap_w64;
        logic trap_w32;
        logic ok;
    } outcome_t;

    localparam logic [5:0] TRAP_SYNDROME = 6'h03;

endpackage

// File: rtl/bsr_decode.sv
// Encoding matcher: compares the five move-instruction fields against the
// parameterised encoding of this register. Purely combinational.
module bsr_decode #(
    parameter logic [3:0] M_COPROC = 4'b1111,
    parameter logic [2:0] M_OPC1   = 3'b000,
    parameter logic [3:0] M_CRN    = 4'b0101,
    parameter logic [3:0] M_CRM    = 4'b0001,
    parameter logic [2:0] M_OPC2   = 3'b000
) (
    input  logic [3:0] coproc,
    input  logic [2:0] opc1,
    input  logic [3:0] crn,
    input  logic [3:0] crm,
    input  logic [2:0] opc2,
    output logic       match
);

    // Field-by-field equality, all must agree.
    always_comb begin
        match = (coproc == M_COPROC) && (opc1 == M_OPC1) && (crn == M_CRN)
             && (crm == M_CRM) && (opc2 == M_OPC2);
    end

endmodule

// File: rtl/bsr_policy.sv
// Outcome and bank selection for one request. Assumes the caller has
// already established that the encoding matches; 'fire' gates all outcomes.
// Trap priority at the supervisor level: group trap, then memory-control trap.
module bsr_policy
    import bsr_pkg::*;
(
    input  logic       fire,
    input  logic       is_write,
    input  logic [1:0] level,
    input  logic       nonsecure,
    input  logic       el2_enabled,
    input  logic       el2_is32,
    input  logic       el3_present,
    input  logic       el3_is32,
    input  logic       grp_w64,
    input  logic       grp_w32,
    input  logic       vmrd_w64,
    input  logic       vmrd_w32,
    input  logic       vmwr_w64,
    input  logic       vmwr_w32,
    output outcome_t   outcome,
    output logic [5:0] code,
    output bank_e      bank_sel
);

    logic grp_hit;
    logic vm_hit;
    logic mon_banked;
    logic any_trap;

    // Pick the trap-bit copies that match the hypervisor width.
    always_comb begin
        grp_hit = el2_enabled && (el2_is32 ? grp_w32 : grp_w64);
        if (is_write) begin
            vm_hit = el2_enabled && (el2_is32 ? vmwr_w32 : vmwr_w64);
        end else begin
            vm_hit = el2_enabled && (el2_is32 ? vmrd_w32 : vmrd_w64);
        end
        mon_banked = el3_present && el3_is32;
    end

    // Decide the single outcome and the bank for this request.
    always_comb begin
        outcome  = '0;
        bank_sel = BANK_ONE;
        any_trap = 1'b0;
        unique case (level_e'(level))
            LVL_USER: outcome.undef = 1'b1;
            LVL_SUPV: begin
                if (grp_hit || vm_hit) begin
                    any_trap = 1'b1;
                end else begin
                    outcome.ok = 1'b1;
                    if (mon_banked) begin
                        bank_sel = nonsecure ? BANK_NS : BANK_SEC;
                    end
                end
            end
            LVL_HYP: begin
                outcome.ok = 1'b1;
                bank_sel   = mon_banked ? BANK_NS : BANK_ONE;
            end
            default: begin
                outcome.ok = 1'b1;
                bank_sel   = nonsecure ? BANK_NS : BANK_SEC;
            end
        endcase
        outcome.trap_w32 = any_trap && el2_is32;
        outcome.trap_w64 = any_trap && !el2_is32;
        if (!fire) begin
            outcome = '0;
        end
        code = (fire && any_trap) ? TRAP_SYNDROME : 6'h00;
    end

endmodule

// File: rtl/bsr_bank_store.sv
// Storage for the banked register copies. Contents are deliberately not
// reset. One copy is written per enabled cycle; reads are combinational.
module bsr_bank_store
    import bsr_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int BANKS  = NUM_BANKS,
    localparam int SEL_W = $clog2(BANKS)
) (
    input  logic                    clk,
    input  logic                    wr_en,
    input  logic [SEL_W-1:0]        sel,
    input  logic [DATA_W-1:0]       wdata,
    output logic [DATA_W-1:0]       rd_val,
    output logic [BANKS*DATA_W-1:0] all_vals
);

    logic [DATA_W-1:0] copy_q [BANKS];

    for (genvar b = 0; b < BANKS; b++) begin : g_copy
        // Capture write data into this copy when it is the one selected.
        always_ff @(posedge clk) begin
            if (wr_en && (sel == SEL_W'(b))) begin
                copy_q[b] <= wdata;
            end
        end
        assign all_vals[b*DATA_W +: DATA_W] = copy_q[b];
    end

    // Read multiplexer over the copies; out-of-range selects read zero.
    always_comb begin
        rd_val = '0;
        for (int b = 0; b < BANKS; b++) begin
            if (sel == SEL_W'(b)) begin
                rd_val = copy_q[b];
            end
        end
    end

endmodule

// File: rtl/bsr_access_ctrl.sv
// Top of the banked fault-status register access controller. Decodes the
// move encoding, resolves the outcome and bank in the request cycle, and
// commits completed writes at the next edge. Assumes static configuration
// flags and a request held for one cycle.
module bsr_access_ctrl
    import bsr_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int SEL_W = $clog2(NUM_BANKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [3:0]        enc_coproc,
    input  logic [2:0]        enc_opc1,
    input  logic [3:0]        enc_crn,
    input  logic [3:0]        enc_crm,
    input  logic [2:0]        enc_opc2,
    input  logic [DATA_W-1:0] wdata,
    input  logic [1:0]        cur_el,
    input  logic              nonsecure,
    input  logic              el2_enabled,
    input  logic              el2_is32,
    input  logic              el3_present,
    input  logic              el3_is32,
    input  logic              hyp_grp_trap_w64,
    input  logic              hyp_grp_trap_w32,
    input  logic              hyp_vmrd_trap_w64,
    input  logic              hyp_vmrd_trap_w32,
    input  logic              hyp_vmwr_trap_w64,
    input  logic              hyp_vmwr_trap_w32,
    output logic              hit,
    output logic              res_undef,
    output logic              res_trap_w64,
    output logic              res_trap_w32,
    output logic              res_ok,
    output logic [5:0]        trap_code,
    output logic [DATA_W-1:0] rdata
);

    logic                        fire;
    outcome_t                    outcome;
    bank_e                       bank_sel;
    logic                        store_wr;
    logic [DATA_W-1:0]           store_rd;
    logic [NUM_BANKS*DATA_W-1:0] store_all;
    logic [DATA_W-1:0]           copy_sec;
    logic [DATA_W-1:0]           copy_ns;
    logic [DATA_W-1:0]           copy_one;

    bsr_decode u_decode (
        .coproc (enc_coproc),
        .opc1   (enc_opc1),
        .crn    (enc_crn),
        .crm    (enc_crm),
        .opc2   (enc_opc2),
        .match  (hit)
    );

    // A request acts only when valid and aimed at this register.
    assign fire = req_valid && hit;

    bsr_policy u_policy (
        .fire        (fire),
        .is_write    (req_write),
        .level       (cur_el),
        .nonsecure   (nonsecure),
        .el2_enabled (el2_enabled),
        .el2_is32    (el2_is32),
        .el3_present (el3_present),
        .el3_is32    (el3_is32),
        .grp_w64     (hyp_grp_trap_w64),
        .grp_w32     (hyp_grp_trap_w32),
        .vmrd_w64    (hyp_vmrd_trap_w64),
        .vmrd_w32    (hyp_vmrd_trap_w32),
        .vmwr_w64    (hyp_vmwr_trap_w64),
        .vmwr_w32    (hyp_vmwr_trap_w32),
        .outcome     (outcome),
        .code        (trap_code),
        .bank_sel    (bank_sel)
    );

    // Writes commit only on a completed access outside reset.
    assign store_wr = outcome.ok && req_write && rst_n;

    bsr_bank_store #(
        .DATA_W (DATA_W),
        .BANKS  (NUM_BANKS)
    ) u_store (
        .clk      (clk),
        .wr_en    (store_wr),
        .sel      (SEL_W'(bank_sel)),
        .wdata    (wdata),
        .rd_val   (store_rd),
        .all_vals (store_all)
    );

    // Unpack the copies for the bound checker.
    assign copy_sec = store_all[int'(BANK_SEC)*DATA_W +: DATA_W];
    assign copy_ns  = store_all[int'(BANK_NS)*DATA_W +: DATA_W];
    assign copy_one = store_all[int'(BANK_ONE)*DATA_W +: DATA_W];

    // Drive the outcome pins and gate read data to completed reads.
    always_comb begin
        res_undef    = outcome.undef;
        res_trap_w64 = outcome.trap_w64;
        res_trap_w32 = outcome.trap_w32;
        res_ok       = outcome.ok;
        rdata        = (outcome.ok && !req_write) ? store_rd : '0;
    end

endmodule

// File: rtl/bsr_access_ctrl_chk.sv
// Property checker for bsr_access_ctrl, attached by bind below.
module bsr_access_ctrl_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic              hit,
    input logic [DATA_W-1:0] wdata,
    input logic [1:0]        cur_el,
    input logic              nonsecure,
    input logic              el2_enabled,
    input logic              el2_is32,
    input logic              hyp_grp_trap_w64,
    input logic              hyp_grp_trap_w32,
    input logic              res_undef,
    input logic              res_trap_w64,
    input logic              res_trap_w32,
    input logic              res_ok,
    input logic [5:0]        trap_code,
    input logic [DATA_W-1:0] copy_sec,
    input logic [DATA_W-1:0] copy_ns,
    input logic [DATA_W-1:0] copy_one
);

    logic act;
    logic outs_any;
    logic grp_sel;
    assign act      = req_valid && hit;
    assign outs_any = res_undef || res_trap_w64 || res_trap_w32 || res_ok;
    assign grp_sel  = el2_is32 ? hyp_grp_trap_w32 : hyp_grp_trap_w64;

    a_r1_idle_silent: assert property (@(posedge clk) disable iff (!rst_n)
        !act |-> !outs_any);

    a_r2_user_undef: assert property (@(posedge clk) disable iff (!rst_n)
        (act && cur_el == 2'd0) |-> res_undef);

    a_r3_group_trap: assert property (@(posedge clk) disable iff (!rst_n)
        (act && cur_el == 2'd1 && el2_enabled && grp_sel)
        |-> ((el2_is32 ? res_trap_w32 : res_trap_w64) && trap_code == 6'h03));

    a_r7_hyp_completes: assert property (@(posedge clk) disable iff (!rst_n)
        (act && cur_el == 2'd2) |-> res_ok);

    a_r8_mon_ns_copy: assert property (@(posedge clk) disable iff (!rst_n)
        (act && cur_el == 2'd3 && req_write && nonsecure)
        |=> (copy_ns == $past(wdata)));

    a_r8_mon_sec_copy: assert property (@(posedge clk) disable iff (!rst_n)
        (act && cur_el == 2'd3 && req_write && !nonsecure)
        |=> (copy_sec == $past(wdata)));

    a_r9_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        act |-> ($countones({res_undef, res_trap_w64, res_trap_w32, res_ok}) == 1));

    a_r9_code_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !(res_trap_w64 || res_trap_w32) |-> (trap_code == 6'h00));

    a_r10_hold_copies: assert property (@(posedge clk) disable iff (!rst_n)
        !(res_ok && req_write)
        |=> ($stable(copy_sec) && $stable(copy_ns) && $stable(copy_one)));

endmodule

bind bsr_access_ctrl bsr_access_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .req_valid        (req_valid),
    .req_write        (req_write),
    .hit              (hit),
    .wdata            (wdata),
    .cur_el           (cur_el),
    .nonsecure        (nonsecure),
    .el2_enabled      (el2_enabled),
    .el2_is32         (el2_is32),
    .hyp_grp_trap_w64 (hyp_grp_trap_w64),
    .hyp_grp_trap_w32 (hyp_grp_trap_w32),
    .res_undef        (res_undef),
    .res_trap_w64     (res_trap_w64),
    .res_trap_w32     (res_trap_w32),
    .res_ok           (res_ok),
    .trap_code        (trap_code),
    .copy_sec         (copy_sec),
    .copy_ns          (copy_ns),
    .copy_one         (copy_one)
);

// File: tb/bsr_access_ctrl_bench.sv
`timescale 1ns/100ps
module bsr_access_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_write;
    logic [3:0]  enc_coproc, enc_crn, enc_crm;
    logic [2:0]  enc_opc1, enc_opc2;
    logic [31:0] wdata;
    logic [1:0]  cur_el;
    logic        nonsecure, el2_enabled, el2_is32, el3_present, el3_is32;
    logic [5:0]  tbits;
    logic        hit, res_undef, res_trap_w64, res_trap_w32, res_ok;
    logic [5:0]  trap_code;
    logic [31:0] rdata;

    int total = 0;
    int bad   = 0;
    logic [31:0] model [3];
    bit          known [3];

    always #2.5 clk = ~clk;

    bsr_access_ctrl u_bsr_access_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .enc_coproc(enc_coproc), .enc_opc1(enc_opc1), .enc_crn(enc_crn),
        .enc_crm(enc_crm), .enc_opc2(enc_opc2), .wdata(wdata), .cur_el(cur_el),
        .nonsecure(nonsecure), .el2_enabled(el2_enabled), .el2_is32(el2_is32),
        .el3_present(el3_present), .el3_is32(el3_is32),
        .hyp_grp_trap_w64(tbits[0]), .hyp_grp_trap_w32(tbits[1]),
        .hyp_vmrd_trap_w64(tbits[2]), .hyp_vmrd_trap_w32(tbits[3]),
        .hyp_vmwr_trap_w64(tbits[4]), .hyp_vmwr_trap_w32(tbits[5]),
        .hit(hit), .res_undef(res_undef), .res_trap_w64(res_trap_w64),
        .res_trap_w32(res_trap_w32), .res_ok(res_ok), .trap_code(trap_code),
        .rdata(rdata)
    );

    task automatic check(input bit cond, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        total++;
        if (!cond) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic set_match();
        enc_coproc = 4'b1111; enc_opc1 = 3'b000; enc_crn = 4'b0101;
        enc_crm = 4'b0001; enc_opc2 = 3'b000;
    endtask

    // One request: drive after an edge, sample mid-cycle, update model after the edge.
    task automatic access(input logic [1:0] el, input logic [3:0] cfg, input bit ns,
                          input bit wr, input logic [5:0] tb, input logic [31:0] d);
        logic [3:0] exp_o;  // {undef, trap_w64, trap_w32, ok}
        int         bank;
        bit         trap, grp, vm, banked;
        string      tag;
        @(posedge clk); #1;
        req_valid = 1'b1; req_write = wr; wdata = d; cur_el = el; nonsecure = ns;
        {el2_enabled, el2_is32, el3_present, el3_is32} = cfg; tbits = tb;
        set_match();
        banked = el3_present && el3_is32;
        grp = el2_enabled && (el2_is32 ? tb[1] : tb[0]);
        vm  = el2_enabled && (wr ? (el2_is32 ? tb[5] : tb[4]) : (el2_is32 ? tb[3] : tb[2]));
        trap = 1'b0; bank = 2; exp_o = 4'b0001;
        case (el)
            2'd0: begin exp_o = 4'b1000; tag = "R2"; end
            2'd1: begin
                tag = !el2_enabled ? "R5" : (grp ? "R3" : (vm ? "R4" : "R6"));
                if (grp || vm) begin
                    trap = 1'b1;
                    exp_o = el2_is32 ? 4'b0010 : 4'b0100;
                end else if (banked) bank = ns ? 1 : 0;
            end
            2'd2: begin bank = banked ? 1 : 2; tag = "R7"; end
            default: begin bank = ns ? 1 : 0; tag = "R8"; end
        endcase
        #1;
        check(hit === 1'b1, "R1 hit", 64'(hit), 64'd1);
        check({res_undef, res_trap_w64, res_trap_w32, res_ok} === exp_o,
              {tag, " R9 outcome"}, 64'({res_undef, res_trap_w64, res_trap_w32, res_ok}),
              64'(exp_o));
        check(trap_code === (trap ? 6'h03 : 6'h00), {tag, " code"},
              64'(trap_code), trap ? 64'h3 : 64'h0);
        if (exp_o[0] && !wr && known[bank])
            check(rdata === model[bank], {tag, " R10 read"}, 64'(rdata), 64'(model[bank]));
        if (!(exp_o[0] && !wr))
            check(rdata === 32'h0, "R10 rdata idle", 64'(rdata), 64'h0);
        @(posedge clk); #0.5;
        if (exp_o[0] && wr) begin model[bank] = d; known[bank] = 1'b1; end
        req_valid = 1'b0;
    endtask

    // Request with a corrupted field or no valid; then confirm nothing acted.
    task automatic probe_silent(input int field, input bit valid);
        @(posedge clk); #1;
        req_valid = valid; req_write = 1'b1; wdata = 32'hDEAD_0000 + field;
        cur_el = 2'd3; nonsecure = 1'b0; set_match();
        case (field)
            0: enc_coproc[field % 4] = ~enc_coproc[field % 4];
            1: enc_opc1[0] = 1'b1;
            2: enc_crn[1] = 1'b1;
            3: enc_crm[0] = 1'b0;
            4: enc_opc2[2] = 1'b1;
            default: ;
        endcase
        #1;
        if (valid) check(hit === 1'b0, "R1 miss hit", 64'(hit), 64'd0);
        check({res_undef, res_trap_w64, res_trap_w32, res_ok} === 4'b0, "R1 silent",
              64'({res_undef, res_trap_w64, res_trap_w32, res_ok}), 64'd0);
        @(posedge clk); #0.5;
        req_valid = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] seed;
        rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; wdata = '0; cur_el = '0;
        nonsecure = 1'b0; {el2_enabled, el2_is32, el3_present, el3_is32} = '0;
        tbits = '0; set_match();
        for (int i = 0; i < 3; i++) known[i] = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check({res_undef, res_trap_w64, res_trap_w32, res_ok} === 4'b0, "R9 reset idle",
              64'({res_undef, res_trap_w64, res_trap_w32, res_ok}), 64'd0);
        rst_n = 1'b1;
        // Seed all three copies with known values.
        access(2'd3, 4'b0000, 1'b0, 1'b1, 6'h00, 32'h5EC0_0001);
        access(2'd3, 4'b0000, 1'b1, 1'b1, 6'h00, 32'h0A5A_0002);
        access(2'd2, 4'b0000, 1'b0, 1'b1, 6'h00, 32'h0E0E_0003);
        seed = 32'h1234_5678;
        for (int el = 0; el < 4; el++)
            for (int cfg = 0; cfg < 16; cfg++)
                for (int ns = 0; ns < 2; ns++)
                    for (int wr = 0; wr < 2; wr++)
                        for (int t = 0; t < 64; t++) begin
                            seed = seed * 32'd1664525 + 32'd1013904223;
                            access(2'(el), 4'(cfg), ns[0], wr[0], 6'(t), seed);
                        end
        for (int f = 0; f < 5; f++) probe_silent(f, 1'b1);
        probe_silent(9, 1'b0);
        // Read each copy back: the silent probes must have changed nothing.
        access(2'd3, 4'b0000, 1'b0, 1'b0, 6'h00, 32'h0);
        access(2'd3, 4'b0000, 1'b1, 1'b0, 6'h00, 32'h0);
        access(2'd2, 4'b0000, 1'b0, 1'b0, 6'h00, 32'h0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule